// File: doc/BRIEF.md
# GPIO Signal Routing Crossbar

This block sits between a bank of bidirectional pads and the peripherals of a chip. It decides which peripheral signal drives each pad and which signal controls whether the pad drives or floats. It also decides which pad level, or which constant, feeds each peripheral input. Every path is set by a 32-bit configuration word on a simple word-addressed read/write bus. Each output-side path can be inverted.

On the output side, each pad has two selectors: one for its data and one for its active-low enable. A selector index of 0 or 1 picks a constant, so software can drive a pad or float it directly. Higher indices pick peripheral output signals. On the input side, pad levels pass through a two-flop synchronizer. They then feed the peripheral input routing and a readback of pad levels in 32-bit banks. The bus uses byte offsets. Accesses are word-aligned, and the two low address bits are ignored.

Top module: `gpiox_crossbar`

## Requirements
- R1: After a synchronous reset, every configuration register holds its reset value: pad-data words 0, enable words 1 and input-routing words 0. In the first cycle after reset, `pad_oe_n` is all ones, `pad_out` is all zeros and `periph_in` is all zeros.
- R2: The data word of pad p is at byte offset 0x50 + 8·p, and bits 30:0 hold an index. Index 0 drives the pad with 0 and index 1 drives it with 1. Index k+2 drives it with `periph_out[k]`.
- R3: When bit 31 of a pad-data or enable word is set, the value resolved from the index is inverted.
- R4: An output-side index at or above NSRC+2 resolves to 0 before the inversion of bit 31 is applied.
- R5: The enable word of pad p is at byte offset 0x54 + 8·p and has the same layout as the data word. `pad_oe_n[p]` carries the resolved value, where 0 drives the pad and 1 releases it.
- R6: The routing word of peripheral input i is at byte offset 0x250 + 4·i. Value 0 feeds 0 and value 1 feeds 1. Value n+2 feeds the synchronized level of pad n, for n from 0 to NPAD-1, and any larger value feeds 0.
- R7: A change on `pad_in` reaches `periph_in` on the third rising edge after it and is not visible after the second.
- R8: A read of byte offset 0x48 returns pads 31..0, and a read of 0x4C returns pads 63..32. Bit (p mod 32) holds the synchronized level of pad p.
- R9: Configuration words read back exactly as last written, including bit 31. A read of an unmapped offset returns 0. `rdata` is valid one cycle after `rd_en`.
- R10: A configuration write stored on one clock edge changes the pad outputs on the following edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | NPAD | Raw pad input levels |
| pad_out | output | NPAD | Pad output data |
| pad_oe_n | output | NPAD | Pad enable, 0 drives the pad |
| periph_out | input | NSRC | Peripheral output signals |
| periph_in | output | NDST | Routed peripheral input signals |

## Verification
A corrupted selector or invert bit shows up as a wrong level on one pad, two edges after the write that should have set it. A wrong level on a peripheral input shows three edges after a pad change. The register readback exposes the stored word one cycle after the read strobe. An off-by-one in address decoding or in the index offset of two shows up as the wrong pad or signal answering. The bench probes the lowest and highest pads, the first out-of-range index and the last valid routing value. A synchronizer that is one stage short is caught by a sample taken after two edges, which must still show the old level.

// File: rtl/gpiox_pkg.sv
package gpiox_pkg;
  typedef logic [31:0] cfg_word_t;
  localparam int BANK_BASE = 'h048;
  localparam int OUT_BASE  = 'h050;
  localparam int INV_BIT   = 31;
endpackage

// File: rtl/gpiox_regs.sv
module gpiox_regs
  import gpiox_pkg::*;
#(
  parameter int NPAD   = 64,
  parameter int NDST   = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  cfg_word_t         wdata,
  output cfg_word_t         rdata,
  input  logic [NPAD-1:0]   pad_sync,
  output cfg_word_t         dout_cfg  [NPAD],
  output cfg_word_t         oe_cfg    [NPAD],
  output cfg_word_t         route_cfg [NDST]
);
  localparam int NBANK = (NPAD + 31) / 32;
  localparam int PW = (NPAD > 1) ? $clog2(NPAD) : 1;
  localparam int RW = (NDST > 1) ? $clog2(NDST) : 1;
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [ADDR_W-1:0] OUT_LO  = ADDR_W'(OUT_BASE);
  localparam logic [ADDR_W-1:0] IN_LO   = ADDR_W'(OUT_BASE + 8 * NPAD);
  localparam logic [ADDR_W-1:0] IN_HI   = ADDR_W'(OUT_BASE + 8 * NPAD + 4 * NDST);
  localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] BANK_HI = ADDR_W'(BANK_BASE + 4 * NBANK);

  logic              is_out, is_in, is_bank, sub_oe;
  logic [ADDR_W-1:0] off_out, off_in, off_bank;
  logic [PW-1:0]     pidx;
  logic [RW-1:0]     ridx;
  logic [BW-1:0]     bidx;
  logic [NBANK*32-1:0] bank_vec;

  always_comb begin
    off_out  = addr - OUT_LO;
    off_in   = addr - IN_LO;
    off_bank = addr - BANK_LO;
    is_out   = (addr >= OUT_LO) && (addr < IN_LO);
    is_in    = (addr >= IN_LO) && (addr < IN_HI);
    is_bank  = (addr >= BANK_LO) && (addr < BANK_HI);
    sub_oe   = off_out[2];
    pidx     = PW'(off_out >> 3);
    ridx     = RW'(off_in >> 2);
    bidx     = BW'(off_bank >> 2);
    bank_vec = (NBANK*32)'(pad_sync);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPAD; p++) begin
        dout_cfg[p] <= '0;
        oe_cfg[p]   <= 32'd1;
      end
      for (int i = 0; i < NDST; i++) route_cfg[i] <= '0;
    end else if (wr_en) begin
      if (is_out) begin
        if (sub_oe) oe_cfg[pidx] <= wdata;
        else        dout_cfg[pidx] <= wdata;
      end else if (is_in) begin
        route_cfg[ridx] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      if (is_out)       rdata <= sub_oe ? oe_cfg[pidx] : dout_cfg[pidx];
      else if (is_in)   rdata <= route_cfg[ridx];
      else if (is_bank) rdata <= bank_vec[bidx*32 +: 32];
      else              rdata <= '0;
    end
  end

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !is_out && !is_in && !is_bank) |=> (rdata == '0));
endmodule

// File: rtl/gpiox_out_sel.sv
module gpiox_out_sel
  import gpiox_pkg::*;
#(
  parameter int NPAD = 64,
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  cfg_word_t       dout_cfg [NPAD],
  input  cfg_word_t       oe_cfg   [NPAD],
  input  logic [NSRC-1:0] periph_out,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] pad_oe_n
);
  localparam int SRC_W = NSRC + 2;
  localparam int IW    = $clog2(SRC_W);

  logic [SRC_W-1:0] src_vec;
  assign src_vec = {periph_out, 1'b1, 1'b0};

  function automatic logic resolve(input cfg_word_t cfg, input logic [SRC_W-1:0] src);
    logic v;
    v = 1'b0;
    if (cfg[30:0] < 31'(SRC_W)) v = src[cfg[IW-1:0]];
    return v ^ cfg[INV_BIT];
  endfunction

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[p]  <= 1'b0;
        pad_oe_n[p] <= 1'b1;
      end else begin
        pad_out[p]  <= resolve(dout_cfg[p], src_vec);
        pad_oe_n[p] <= resolve(oe_cfg[p], src_vec);
      end
    end

    // R4
    oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ((dout_cfg[p][30:0] >= 31'(SRC_W)) && !dout_cfg[p][INV_BIT]) |=> !pad_out[p]);
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((pad_oe_n == '1) && (pad_out == '0)));
endmodule

// File: rtl/gpiox_in_route.sv
module gpiox_in_route
  import gpiox_pkg::*;
#(
  parameter int NPAD = 64,
  parameter int NDST = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPAD-1:0] pad_in,
  input  cfg_word_t       route_cfg [NDST],
  output logic [NPAD-1:0] pad_sync,
  output logic [NDST-1:0] periph_in
);
  localparam int SRC_W = NPAD + 2;
  localparam int IW    = $clog2(SRC_W);

  logic [NPAD-1:0]  meta_q;
  logic [SRC_W-1:0] src_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      pad_sync <= '0;
    end else begin
      meta_q   <= pad_in;
      pad_sync <= meta_q;
    end
  end

  assign src_vec = {pad_sync, 1'b1, 1'b0};

  for (genvar i = 0; i < NDST; i++) begin : g_dst
    always_ff @(posedge clk) begin
      if (rst) periph_in[i] <= 1'b0;
      else if (route_cfg[i] < 32'(SRC_W)) periph_in[i] <= src_vec[route_cfg[i][IW-1:0]];
      else periph_in[i] <= 1'b0;
    end

    // R6
    route_const_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(route_cfg[i]) == 32'd1) |-> periph_in[i]);
  end
endmodule

// File: rtl/gpiox_crossbar.sv
module gpiox_crossbar
  import gpiox_pkg::*;
#(
  parameter int NPAD   = 64,
  parameter int NSRC   = 32,
  parameter int NDST   = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPAD-1:0]   pad_in,
  output logic [NPAD-1:0]   pad_out,
  output logic [NPAD-1:0]   pad_oe_n,
  input  logic [NSRC-1:0]   periph_out,
  output logic [NDST-1:0]   periph_in
);
  cfg_word_t       dout_cfg  [NPAD];
  cfg_word_t       oe_cfg    [NPAD];
  cfg_word_t       route_cfg [NDST];
  logic [NPAD-1:0] pad_sync;

  gpiox_regs #(.NPAD(NPAD), .NDST(NDST), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_sync(pad_sync),
    .dout_cfg(dout_cfg), .oe_cfg(oe_cfg), .route_cfg(route_cfg)
  );

  gpiox_out_sel #(.NPAD(NPAD), .NSRC(NSRC)) u_out (
    .clk(clk), .rst(rst), .dout_cfg(dout_cfg), .oe_cfg(oe_cfg),
    .periph_out(periph_out), .pad_out(pad_out), .pad_oe_n(pad_oe_n)
  );

  gpiox_in_route #(.NPAD(NPAD), .NDST(NDST)) u_in (
    .clk(clk), .rst(rst), .pad_in(pad_in), .route_cfg(route_cfg),
    .pad_sync(pad_sync), .periph_in(periph_in)
  );
endmodule

// File: tb/gpiox_crossbar_bench.sv
module gpiox_crossbar_bench;
  logic        clk = 1'b0;
  logic        rst, wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, rv;
  logic [63:0] pad_in, pad_out, pad_oe_n;
  logic [31:0] periph_out;
  logic [15:0] periph_in;
  logic [71:0] e;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpiox_crossbar u_gpiox_crossbar (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe_n(pad_oe_n), .periph_out(periph_out), .periph_in(periph_in)
  );

  // fields: pad[71:66] is_oe[65] cfg[64:33] periph[32:1] expected[0]
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {6'd0,  1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R2 const 1
    {6'd0,  1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}, // R2 const 0
    {6'd5,  1'b0, 32'h0000_0005, 32'h0000_0008, 1'b1}, // R2 periph 3
    {6'd5,  1'b0, 32'h8000_0005, 32'h0000_0008, 1'b0}, // R3 inverted
    {6'd63, 1'b0, 32'h0000_0021, 32'h8000_0000, 1'b1}, // R2 last signal
    {6'd63, 1'b0, 32'h0000_0022, 32'hFFFF_FFFF, 1'b0}, // R4 first out of range
    {6'd63, 1'b0, 32'h8000_0022, 32'hFFFF_FFFF, 1'b1}, // R4 then R3 inversion
    {6'd10, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R5 drive
    {6'd10, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b1}, // R5 inverted release
    {6'd10, 1'b1, 32'h0000_0009, 32'h0000_0080, 1'b1}, // R5 periph 7 high
    {6'd10, 1'b1, 32'h0000_0009, 32'h0000_0000, 1'b0}  // R5 periph 7 low
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    pad_in = '0; periph_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 pad_oe_n", pad_oe_n, '1);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 periph_in", 64'(periph_in), '0);
    rd(12'h054 + 12'd160, rv); chk("R1 enable word", 64'(rv), 64'd1);
    rd(12'h050 + 12'd56, rv);  chk("R1 data word", 64'(rv), 64'd0);
    rd(12'h250 + 12'd20, rv);  chk("R1 route word", 64'(rv), 64'd0);

    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      periph_out = e[32:1];
      wr(12'h050 + 12'(e[71:66]) * 12'd8 + (e[65] ? 12'd4 : 12'd0), e[64:33]);
      tick(1);
      if (e[65]) chk($sformatf("R5 vector %0d", v), 64'(pad_oe_n[e[71:66]]), 64'(e[0]));
      else       chk($sformatf("R2/R3/R4 vector %0d", v), 64'(pad_out[e[71:66]]), 64'(e[0]));
    end

    // R10: one edge of delay from stored write to pad output
    wr(12'h050 + 12'd8, 32'd1);
    chk("R10 before edge", 64'(pad_out[1]), 64'd0);
    tick(1);
    chk("R10 after edge", 64'(pad_out[1]), 64'd1);

    // R9 readback
    wr(12'h050 + 12'd96, 32'hDEAD_BEEF);
    rd(12'h050 + 12'd96, rv); chk("R9 data readback", 64'(rv), 64'hDEAD_BEEF);
    rd(12'h054 + 12'd80, rv); chk("R9 enable readback", 64'(rv), 64'h0000_0009);
    rd(12'h000, rv);          chk("R9 unmapped low", 64'(rv), 64'd0);
    rd(12'h290, rv);          chk("R9 unmapped past routing", 64'(rv), 64'd0);

    // R6/R7: input 3 routed to pad 40
    wr(12'h250 + 12'd12, 32'd42);
    pad_in[40] = 1'b1;
    tick(2);
    chk("R7 not after two edges", 64'(periph_in[3]), 64'd0);
    tick(1);
    chk("R7 third edge", 64'(periph_in[3]), 64'd1);
    chk("R6 pad 40", 64'(periph_in[3]), 64'd1);
    pad_in = '0;
    tick(3);
    chk("R6 pad 40 low", 64'(periph_in[3]), 64'd0);
    wr(12'h250 + 12'd12, 32'd1);
    tick(1);
    chk("R6 constant 1", 64'(periph_in[3]), 64'd1);
    pad_in = '1;
    wr(12'h250 + 12'd12, 32'd66);
    tick(3);
    chk("R6 value 66 gives 0", 64'(periph_in[3]), 64'd0);
    wr(12'h250 + 12'd12, 32'd65);
    tick(1);
    chk("R6 value 65 pad 63", 64'(periph_in[3]), 64'd1);
    rd(12'h250 + 12'd12, rv); chk("R9 route readback", 64'(rv), 64'd65);

    // R8 bank readback
    pad_in = 64'hA5A5_0F0F_1234_5678;
    tick(3);
    rd(12'h048, rv); chk("R8 bank 0", 64'(rv), 64'h1234_5678);
    rd(12'h04C, rv); chk("R8 bank 1", 64'(rv), 64'hA5A5_0F0F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule